// File: doc/BRIEF.md
# Interrupt Polarity Normalizing Controller

This block sits between a set of raw interrupt lines and a downstream interrupt controller that accepts only active-high levels and rising edges. Each input pin has its own 3-bit sense code and an enable bit. The block turns low-level, falling-edge and both-edge sources into signals that the downstream controller can take. Level modes pass the input through or invert it. Edge modes produce a one-clock high pulse for each qualifying transition.

Every raw input first passes through a two-flop synchronizer. A previous-value flop then feeds edge detection. A 32-bit register port with word addresses holds the configuration. The enable bank starts at word address 4 (byte 0x10), with pin p at word 4 + p/32, bit p%32. The per-pin sense words start at word address 68 (byte 0x110), so pin p sits at word 68 + p. Any pin whose enable bit is clear, or whose sense code is not defined, keeps its output low.

Top module: `irq_normalizer`

## Requirements
- R1: After reset, all enable bits read 0, every sense word reads 4 (3'b100), and every output is low.
- R2: Sense code 3'b100 with enable set: the output equals the input as it was two rising clock edges earlier.
- R3: Sense code 3'b000 with enable set: the output is the inverse of the input as it was two rising clock edges earlier.
- R4: Sense code 3'b110 with enable set: a 0-to-1 input change gives a single high cycle on the output. The pulse comes right after the second rising edge that follows the change. A 1-to-0 change gives no pulse.
- R5: Sense code 3'b010 with enable set: a 1-to-0 input change gives a single high cycle, with the same timing as R4. A 0-to-1 change gives no pulse.
- R6: Sense code 3'b111 with enable set: every input change, in either direction, gives a single high cycle with the timing of R4.
- R7: Sense codes 3'b001, 3'b011 and 3'b101 hold the output low whatever the input does.
- R8: A pin whose enable bit is 0 holds its output low in every sense mode.
- R9: A write to enable word 4 + k sets the enable bits of pins 32k..32k+31 from data bits 0..31. It leaves the other enable words and all sense words unchanged, and the word reads back as written.
- R10: A write to word 68 + p stores data bits [2:0] as the sense code of pin p. It leaves the enables and the other pins unchanged. Reads return the code zero-extended to 32 bits.
- R11: Enable bits for pins at or above the pin count read 0 and cannot be set. Reads of unmapped word addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_PINS | Raw interrupt inputs, asynchronous |
| we_i | input | 1 | Register write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| irq_o | output | NUM_PINS | Normalized active-high interrupt outputs |

## Verification
The assertions check on every cycle that an edge-mode pulse occurs only alongside a matching change of the synchronized input. They also check that a write to the sense region never alters an enable, that a write to the enable region never alters a sense code, and that each enable word changes only when it is addressed. Several behaviours are shown only by the bench's sweeps, which run every sense code under three enable patterns and compare every output against a bench-side pipeline model: the level mappings, the masking by clear enables, the silence of undefined codes and the exact two-edge latency. Read-back values, zeros for unimplemented bits and unmapped addresses, and the reset state are likewise shown only by the bench.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  localparam logic [2:0] SENSE_LVL_LO    = 3'b000;
  localparam logic [2:0] SENSE_EDGE_FALL = 3'b010;
  localparam logic [2:0] SENSE_LVL_HI    = 3'b100;
  localparam logic [2:0] SENSE_EDGE_RISE = 3'b110;
  localparam logic [2:0] SENSE_EDGE_BOTH = 3'b111;

  localparam int EN_BASE_WORD  = 4;   // byte 0x10
  localparam int CFG_BASE_WORD = 68;  // byte 0x110
endpackage

// File: rtl/irqn_sync.sv
module irqn_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/irqn_pin.sv
module irqn_pin
  import irqn_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       en_i,
  input  logic [2:0] sense_i,
  output logic       irq_o
);
  logic prev_q, rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_i;
  end

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    case (sense_i)
      SENSE_LVL_LO:    hit = ~sync_i;
      SENSE_LVL_HI:    hit = sync_i;
      SENSE_EDGE_FALL: hit = fall;
      SENSE_EDGE_RISE: hit = rise;
      SENSE_EDGE_BOTH: hit = rise | fall;
      default:         hit = 1'b0;
    endcase
  end

  assign irq_o = en_i & hit;

  a_r4_rise_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_EDGE_RISE && irq_o) |-> (sync_i && !$past(sync_i)));
  a_r5_fall_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_EDGE_FALL && irq_o) |-> (!sync_i && $past(sync_i)));
  a_r6_dual_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_EDGE_BOTH && irq_o) |-> (sync_i != $past(sync_i)));
endmodule

// File: rtl/irqn_regs.sv
module irqn_regs
  import irqn_pkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic [NUM_PINS-1:0]      en_o,
  output logic [NUM_PINS-1:0][2:0] cfg_o
);
  localparam int EN_WORDS = (NUM_PINS + 31) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;
  localparam logic [EN_BITS:0]   ONE_SH  = (EN_BITS+1)'(1) << NUM_PINS;
  localparam logic [EN_BITS-1:0] EN_MASK = EN_BITS'(ONE_SH - 1'b1);

  logic [EN_BITS-1:0]        en_q;
  logic [NUM_PINS-1:0][2:0]  cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= SENSE_LVL_HI;
    end else if (we_i) begin
      for (int w = 0; w < EN_WORDS; w++)
        if (addr_i == ADDR_W'(EN_BASE_WORD + w))
          en_q[w*32 +: 32] <= wdata_i & EN_MASK[w*32 +: 32];
      for (int p = 0; p < NUM_PINS; p++)
        if (addr_i == ADDR_W'(CFG_BASE_WORD + p))
          cfg_q[p] <= wdata_i[2:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < EN_WORDS; w++)
      if (addr_i == ADDR_W'(EN_BASE_WORD + w)) rdata_o = en_q[w*32 +: 32];
    for (int p = 0; p < NUM_PINS; p++)
      if (addr_i == ADDR_W'(CFG_BASE_WORD + p)) rdata_o = {29'd0, cfg_q[p]};
  end

  assign en_o  = en_q[NUM_PINS-1:0];
  assign cfg_o = cfg_q;

  a_r10_cfg_write_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(CFG_BASE_WORD)) |=> $stable(en_q));
  a_r9_en_write_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i < ADDR_W'(CFG_BASE_WORD)) |=> $stable(cfg_q));

  for (genvar w = 0; w < EN_WORDS; w++) begin : g_word_chk
    a_r9_word_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(EN_BASE_WORD + w)) |=> $stable(en_q[w*32 +: 32]));
  end
endmodule

// File: rtl/irq_normalizer.sv
module irq_normalizer
  import irqn_pkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic [NUM_PINS-1:0]      sync;
  logic [NUM_PINS-1:0]      en;
  logic [NUM_PINS-1:0][2:0] cfg;

  irqn_sync #(.W(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_i),
    .sync_o  (sync)
  );

  irqn_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .cfg_o   (cfg)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irqn_pin u_pin (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[p]),
      .en_i    (en[p]),
      .sense_i (cfg[p]),
      .irq_o   (irq_o[p])
    );
  end
endmodule

// File: tb/irq_normalizer_tb_top.sv
module irq_normalizer_tb_top;
  localparam int NP = 40;
  localparam int AW = 8;
  localparam int ENB = 4;
  localparam int CFB = 68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NP-1:0] raw = '0;
  logic [NP-1:0] irq;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  int n_tests = 0;
  int n_fail  = 0;

  irq_normalizer #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_i (raw), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  // bench pipeline: p2 = input two edges back, p3 = three edges back
  logic [NP-1:0] p1, p2, p3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; p3 <= '0;
    end else begin
      p1 <= raw; p2 <= p1; p3 <= p2;
    end
  end

  logic [2:0]    sh_cfg [NP];
  logic [NP-1:0] sh_en;
  logic [63:0]   lfsr = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic model(input logic [2:0] c, input logic e, input logic s, input logic d);
    logic h;
    case (c)
      3'b100: h = s;
      3'b000: h = ~s;
      3'b110: h = s & ~d;
      3'b010: h = ~s & d;
      3'b111: h = s ^ d;
      default: h = 1'b0;
    endcase
    return e & h;
  endfunction

  function automatic string req_of(input logic [2:0] c, input logic e);
    if (!e) return "R8";
    case (c)
      3'b100: return "R2";
      3'b000: return "R3";
      3'b110: return "R4";
      3'b010: return "R5";
      3'b111: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp_v, input string tag);
    @(negedge clk);
    addr = AW'(a);
    #1 chk(tag, rdata, exp_v);
  endtask

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
  endtask

  task automatic check_outputs();
    logic [NP-1:0] ex;
    for (int p = 0; p < NP; p++) ex[p] = model(sh_cfg[p], sh_en[p], p2[p], p3[p]);
    n_tests++;
    if (irq !== ex) begin
      n_fail++;
      for (int p = 0; p < NP; p++)
        if (irq[p] !== ex[p]) begin
          $display("FAIL %s pin %0d code %b actual=%b expected=%b",
                   req_of(sh_cfg[p], sh_en[p]), p, sh_cfg[p], irq[p], ex[p]);
          break;
        end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 outputs low", 32'(irq), 32'd0);
    rd(ENB, 32'd0, "R1 enable word0");
    rd(ENB+1, 32'd0, "R1 enable word1");
    rd(CFB, 32'd4, "R1 cfg pin0");
    rd(CFB+13, 32'd4, "R1 cfg pin13");
    rd(CFB+NP-1, 32'd4, "R1 cfg last pin");

    // R11 unmapped reads
    rd(0, 32'd0, "R11 addr0");
    rd(ENB+2, 32'd0, "R11 enable word past pins");
    rd(CFB+NP, 32'd0, "R11 cfg past pins");

    // R9 enable bank, R11 upper bits
    wr(ENB, 32'hA5A5_0F0F);
    wr(ENB+1, 32'hFFFF_FFFF);
    rd(ENB, 32'hA5A5_0F0F, "R9 word0 readback");
    rd(ENB+1, 32'h0000_00FF, "R11 word1 unimplemented bits");
    wr(ENB, 32'h0);
    rd(ENB+1, 32'h0000_00FF, "R9 word1 untouched");
    rd(CFB+5, 32'd4, "R9 cfg untouched");

    // R10 sense words
    wr(CFB+7, 32'hFFFF_FFFF);
    rd(CFB+7, 32'd7, "R10 cfg zero-extended");
    rd(CFB+6, 32'd4, "R10 neighbour untouched");
    rd(ENB+1, 32'h0000_00FF, "R10 enables untouched");
    rd(ENB, 32'h0, "R10 enables untouched w0");

    // R11 unmapped writes ignored
    wr(0, 32'hFFFF_FFFF);
    wr(ENB+2, 32'hFFFF_FFFF);
    wr(CFB+NP, 32'hFFFF_FFFF);
    rd(ENB, 32'h0, "R11 write ignored w0");
    rd(ENB+1, 32'h0000_00FF, "R11 write ignored w1");
    rd(CFB, 32'd4, "R11 write ignored cfg0");
    rd(ENB+2, 32'h0, "R11 write ignored unmapped");

    // R2-R8 sweep over every code and three enable patterns
    for (int ph = 0; ph < 8; ph++) begin
      for (int em = 0; em < 3; em++) begin
        logic [63:0] ev;
        ev = (em == 0) ? 64'hFFFF_FFFF_FFFF_FFFF :
             (em == 1) ? 64'h5555_5555_5555_5555 : 64'h0;
        for (int p = 0; p < NP; p++) begin
          wr(CFB+p, 32'((p + ph) % 8));
          sh_cfg[p] = 3'((p + ph) % 8);
        end
        wr(ENB, ev[31:0]);
        wr(ENB+1, ev[63:32]);
        sh_en = ev[NP-1:0];
        for (int c = 0; c < 48; c++) begin
          @(negedge clk);
          check_outputs();
          step_lfsr();
          if (c % 8 < 4) raw = lfsr[NP-1:0];
          else if (c % 2 == 0) raw = ~raw;
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule